// File: doc/BRIEF.md
# Load-Use Stall and Operand Forwarding Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back) and decides, every cycle, whether the front of the pipe may advance and where the execute-stage ALU takes its two operands from. A load fetches its data only by the end of the memory stage. An instruction in decode that reads the load's destination register would reach execute one cycle too early. The controller spots that case by comparing register numbers. It then holds the program counter and the fetch/decode register and turns the slot entering the decode/execute register into a no-op.

A mode input picks whether the datapath's bypass paths are in use. With bypassing on, one held cycle is enough, and the loaded value then reaches execute from the memory/write-back register. With bypassing off, the controller holds decode for two cycles so that the dependent instruction reads the register file after the load has been written back, and it steers both operands to the register file at all times. Register 0 always reads as zero, so it never causes a hold and is never bypassed.

Top module: `ldu_hazard_ctrl`

## Requirements
- R1: After reset, with no load in execute and no matching writers, `pc_we` and `ifid_we` are 1, `idex_bubble` is 0 and both operand selects are 0 (register file).
- R2: When `idex_mem_read` is 1 and `idex_rt` is nonzero and equal to `id_rs` or to `id_rt`, the controller holds in that same cycle: `pc_we`=0, `ifid_we`=0, `idex_bubble`=1.
- R3: When `idex_mem_read` is 0, or `idex_rt` matches neither decode source, no hold is started.
- R4: A load whose destination `idex_rt` is 0 never starts a hold, even if a decode source field is also 0.
- R5: With `fwd_en`=1, a load-use hold lasts exactly one cycle: in the next cycle, when execute holds the bubble (no load), the pipeline advances.
- R6: With `fwd_en`=0 at the cycle a hold starts, the hold lasts exactly two cycles. The second held cycle comes even though execute then holds only the bubble.
- R7: With `fwd_en`=1, an operand whose source register equals `exmem_rd`, while `exmem_reg_write`=1 and `exmem_rd` is nonzero, gets select value 2 (bypass from execute/memory).
- R8: With `fwd_en`=1, an operand not served by R7 whose source register equals `memwb_rd`, while `memwb_reg_write`=1 and `memwb_rd` is nonzero, gets select value 1 (bypass from memory/write-back).
- R9: When both later stages write the operand's source register, select value 2 wins over 1.
- R10: A writer with its write enable at 0, or with destination 0, never causes a bypass (select 0).
- R11: With `fwd_en`=0, both operand selects are 0.
- R12: `pc_we` and `ifid_we` are always equal to each other and to the inverse of `idex_bubble`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1: bypass paths in use; 0: register-file-only mode |
| id_rs | input | AW | First source register of the instruction in decode |
| id_rt | input | AW | Second source register of the instruction in decode |
| idex_mem_read | input | 1 | Instruction in execute is a load |
| idex_rt | input | AW | Destination of the load in execute |
| ex_rs | input | AW | First source register of the instruction in execute (operand A) |
| ex_rt | input | AW | Second source register of the instruction in execute (operand B) |
| exmem_reg_write | input | 1 | Instruction in memory stage writes a register |
| exmem_rd | input | AW | Destination of the instruction in memory stage |
| memwb_reg_write | input | 1 | Instruction in write-back writes a register |
| memwb_rd | input | AW | Destination of the instruction in write-back |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control bits entering decode/execute |
| fwd_a_sel | output | 2 | Operand A source: 0 register file, 1 write-back, 2 memory stage |
| fwd_b_sel | output | 2 | Operand B source: same encoding as operand A |

## Verification
The hardest case to reach is the second held cycle of register-file-only mode (R6). It only comes when a load-use match has just been seen with `fwd_en` low, and the inputs in the following cycle show the bubble in execute and no match at all. So nothing on the ports explains the hold except the controller's own memory of the earlier match. The stimulus replays the real pipeline sequence: load and dependent instruction, then the bubble with the load moved on, then the dependent moving forward. It checks both modes back to back. It also runs a long stretch of random register numbers drawn from a range of four, so that matches, register 0 and double writers come up often, while the bench model tracks the pending hold.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

  // Operand source encoding shared by the bypass logic and its checker
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_WB      = 2'd1,
    SRC_MEM     = 2'd2
  } opnd_src_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/ldu_detect.sv
module ldu_detect #(
  parameter int unsigned AW = 5
) (
  input  logic          ld_in_ex,
  input  logic [AW-1:0] ld_dst,
  input  logic [AW-1:0] dec_src0,
  input  logic [AW-1:0] dec_src1,
  output logic          match
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic dst_live;
  logic hit0;
  logic hit1;

  always_comb begin
    dst_live = ld_in_ex && (ld_dst != ZERO_REG);
    hit0     = (ld_dst == dec_src0);
    hit1     = (ld_dst == dec_src1);
    match    = dst_live && (hit0 || hit1);
  end

endmodule

// File: rtl/ldu_stall_seq.sv
module ldu_stall_seq #(
  parameter int unsigned HOLD_BYPASS = 1,
  parameter int unsigned HOLD_NOBYP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_en,
  input  logic match,
  output logic hold
);

  localparam int unsigned HOLD_MAX = (HOLD_BYPASS > HOLD_NOBYP) ? HOLD_BYPASS : HOLD_NOBYP;
  localparam int unsigned CNT_W    = (HOLD_MAX > 1) ? $clog2(HOLD_MAX) : 1;
  localparam logic [CNT_W-1:0] EXTRA_BYP   = CNT_W'(HOLD_BYPASS - 1);
  localparam logic [CNT_W-1:0] EXTRA_NOBYP = CNT_W'(HOLD_NOBYP - 1);
  localparam logic [CNT_W-1:0] CNT_ZERO    = '0;
  localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] left_d;
  logic             left_en;
  logic             pending;

  // next-state: remaining extra held cycles after the one that starts a hold
  always_comb begin
    pending = (left_q != CNT_ZERO);
    left_en = pending || match;
    left_d  = left_q;
    if (pending) begin
      left_d = left_q - CNT_ONE;
    end else if (match) begin
      left_d = byp_en ? EXTRA_BYP : EXTRA_NOBYP;
    end
    hold = pending || match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= CNT_ZERO;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/ldu_fwd_unit.sv
module ldu_fwd_unit
  import ldu_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          byp_en,
  input  logic [AW-1:0] src,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_dst,
  input  logic          wb_wr,
  input  logic [AW-1:0] wb_dst,
  output opnd_src_e     sel
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = byp_en && mem_wr && (mem_dst != ZERO_REG) && (mem_dst == src);
    wb_hit  = byp_en && wb_wr  && (wb_dst  != ZERO_REG) && (wb_dst  == src);
    // the memory stage holds the younger result, so it is checked first
    if (mem_hit) begin
      sel = SRC_MEM;
    end else if (wb_hit) begin
      sel = SRC_WB;
    end else begin
      sel = SRC_REGFILE;
    end
  end

endmodule

// File: rtl/ldu_hazard_ctrl.sv
module ldu_hazard_ctrl
  import ldu_pkg::*;
#(
  parameter int unsigned AW          = 5,
  parameter int unsigned HOLD_BYPASS = 1,
  parameter int unsigned HOLD_NOBYP  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          idex_mem_read,
  input  logic [AW-1:0] idex_rt,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic          exmem_reg_write,
  input  logic [AW-1:0] exmem_rd,
  input  logic          memwb_reg_write,
  input  logic [AW-1:0] memwb_rd,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel
);

  logic            ld_match;
  logic            hold;
  logic [AW-1:0]   ex_src [NUM_OPND];
  opnd_src_e       opnd_sel [NUM_OPND];

  ldu_detect #(.AW(AW)) u_detect (
    .ld_in_ex (idex_mem_read),
    .ld_dst   (idex_rt),
    .dec_src0 (id_rs),
    .dec_src1 (id_rt),
    .match    (ld_match)
  );

  ldu_stall_seq #(
    .HOLD_BYPASS (HOLD_BYPASS),
    .HOLD_NOBYP  (HOLD_NOBYP)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .byp_en (fwd_en),
    .match  (ld_match),
    .hold   (hold)
  );

  always_comb begin
    ex_src[0] = ex_rs;
    ex_src[1] = ex_rt;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    ldu_fwd_unit #(.AW(AW)) u_fwd (
      .byp_en  (fwd_en),
      .src     (ex_src[g]),
      .mem_wr  (exmem_reg_write),
      .mem_dst (exmem_rd),
      .wb_wr   (memwb_reg_write),
      .wb_dst  (memwb_rd),
      .sel     (opnd_sel[g])
    );
  end

  always_comb begin
    pc_we       = !hold;
    ifid_we     = !hold;
    idex_bubble = hold;
    fwd_a_sel   = opnd_sel[0];
    fwd_b_sel   = opnd_sel[1];
  end

endmodule

// File: rtl/ldu_hazard_ctrl_chk.sv
module ldu_hazard_ctrl_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fwd_en,
  input logic [AW-1:0] id_rs,
  input logic [AW-1:0] id_rt,
  input logic          idex_mem_read,
  input logic [AW-1:0] idex_rt,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rt,
  input logic          exmem_reg_write,
  input logic [AW-1:0] exmem_rd,
  input logic          memwb_reg_write,
  input logic [AW-1:0] memwb_rd,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_bubble,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel
);

  logic prev_bub;
  logic ld_hit;

  always_comb begin
    ld_hit = idex_mem_read && (idex_rt != '0) && ((idex_rt == id_rs) || (idex_rt == id_rt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_bub <= 1'b0;
    else        prev_bub <= idex_bubble;
  end

  assert_hold_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> (idex_bubble && !pc_we));

  assert_quiet_without_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_bub && !ld_hit) |-> !idex_bubble);

  assert_single_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_bubble && !prev_bub && fwd_en) |=> (ld_hit || !idex_bubble));

  assert_double_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_bubble && !prev_bub && !fwd_en) |=> idex_bubble);

  assert_zero_src_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs == '0) |-> (fwd_a_sel == 2'd0));

  assert_zero_src_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rt == '0) |-> (fwd_b_sel == 2'd0));

  assert_regfile_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> ((fwd_a_sel == 2'd0) && (fwd_b_sel == 2'd0)));

  assert_mem_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && exmem_reg_write && (exmem_rd != '0) && (exmem_rd == ex_rs)) |-> (fwd_a_sel == 2'd2));

  assert_enables_agree_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == ifid_we) && (pc_we != idex_bubble));

endmodule

bind ldu_hazard_ctrl ldu_hazard_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/ldu_hazard_ctrl_bench.sv
module ldu_hazard_ctrl_bench;

  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic          fwd_en;
  logic [AW-1:0] id_rs, id_rt, idex_rt, ex_rs, ex_rt, exmem_rd, memwb_rd;
  logic          idex_mem_read, exmem_reg_write, memwb_reg_write;
  logic          pc_we, ifid_we, idex_bubble;
  logic [1:0]    fwd_a_sel, fwd_b_sel;

  int n_cmp  = 0;
  int n_bad  = 0;
  int ref_left = 0;   // extra held cycles still owed by the model
  bit done = 0;

  ldu_hazard_ctrl u_ldu_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
    .id_rs(id_rs), .id_rt(id_rt),
    .idex_mem_read(idex_mem_read), .idex_rt(idex_rt),
    .ex_rs(ex_rs), .ex_rt(ex_rt),
    .exmem_reg_write(exmem_reg_write), .exmem_rd(exmem_rd),
    .memwb_reg_write(memwb_reg_write), .memwb_rd(memwb_rd),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  function automatic bit ref_match();
    int d = idex_rt;
    return idex_mem_read && (d != 0) && (d == int'(id_rs) || d == int'(id_rt));
  endfunction

  function automatic int ref_sel(input int src);
    if (!fwd_en) return 0;
    if (exmem_reg_write && exmem_rd != 0 && int'(exmem_rd) == src) return 2;
    if (memwb_reg_write && memwb_rd != 0 && int'(memwb_rd) == src) return 1;
    return 0;
  endfunction

  // model state update on the same edge the design samples
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_left = 0;
    else if (ref_left > 0) ref_left = ref_left - 1;
    else if (ref_match() && !fwd_en) ref_left = 1;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // inputs are set at a falling edge; compare, then let one rising edge pass
  task automatic cyc(input string stag, input string ftag);
    int exp_hold;
    #1;
    exp_hold = (ref_match() || ref_left > 0) ? 1 : 0;
    chk(stag, "idex_bubble", int'(idex_bubble), exp_hold);
    chk("R12", "pc_we", int'(pc_we), 1 - exp_hold);
    chk("R12", "ifid_we", int'(ifid_we), 1 - exp_hold);
    chk(ftag, "fwd_a_sel", int'(fwd_a_sel), ref_sel(int'(ex_rs)));
    chk(ftag, "fwd_b_sel", int'(fwd_b_sel), ref_sel(int'(ex_rt)));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    id_rs = '0; id_rt = '0; idex_mem_read = 0; idex_rt = '0;
    ex_rs = '0; ex_rt = '0; exmem_reg_write = 0; exmem_rd = '0;
    memwb_reg_write = 0; memwb_rd = '0;
  endtask

  // load r5 in EX, dependent reads r5 in decode, then the pipeline moves on
  task automatic load_use_seq(input bit fe);
    fwd_en = fe;
    idle(); idex_mem_read = 1; idex_rt = 5; id_rs = 5; id_rt = 9;
    cyc("R2", "R10");
    // bubble now in EX, load in MEM, dependent still in decode
    idle(); id_rs = 5; id_rt = 9; exmem_reg_write = 1; exmem_rd = 5;
    cyc(fe ? "R5" : "R6", fe ? "R7" : "R11");
    if (!fe) begin
      // bubble in MEM, load in WB, dependent still held
      idle(); id_rs = 5; id_rt = 9; memwb_reg_write = 1; memwb_rd = 5;
      cyc("R6", "R11");
    end
    // dependent in EX
    idle(); ex_rs = 5; ex_rt = 9;
    if (fe) begin memwb_reg_write = 1; memwb_rd = 5; end
    cyc(fe ? "R5" : "R6", fe ? "R8" : "R11");
  endtask

  initial begin
    rst_n = 0; fwd_en = 1; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R1", "R1");
    cyc("R1", "R1");

    load_use_seq(1'b1);
    load_use_seq(1'b0);

    // match through the second decode source
    fwd_en = 1; idle(); idex_mem_read = 1; idex_rt = 7; id_rs = 3; id_rt = 7;
    cyc("R2", "R10");
    idle(); cyc("R5", "R10");

    // independent instruction after a load
    idle(); idex_mem_read = 1; idex_rt = 5; id_rs = 6; id_rt = 8;
    cyc("R3", "R10");
    // non-load whose rt matches
    idle(); idex_mem_read = 0; idex_rt = 6; id_rs = 6; id_rt = 6;
    cyc("R3", "R10");

    // load to register 0 then a use of register 0
    idle(); idex_mem_read = 1; idex_rt = 0; id_rs = 0; id_rt = 0;
    exmem_reg_write = 1; exmem_rd = 0; memwb_reg_write = 1; memwb_rd = 0;
    cyc("R4", "R10");
    fwd_en = 0; cyc("R4", "R11");
    fwd_en = 1;

    // bypass selection cases
    idle(); ex_rs = 2; ex_rt = 3; exmem_reg_write = 1; exmem_rd = 3;
    cyc("R3", "R7");
    memwb_reg_write = 1; memwb_rd = 3;
    cyc("R3", "R9");
    exmem_rd = 2;
    cyc("R3", "R9");
    exmem_reg_write = 0;
    cyc("R3", "R8");
    memwb_reg_write = 0;
    cyc("R3", "R10");
    fwd_en = 0; exmem_reg_write = 1; memwb_reg_write = 1;
    cyc("R3", "R11");

    // random stretch over a small register range
    for (int i = 0; i < 3000; i++) begin
      fwd_en          = ($urandom_range(0, 3) != 0);
      id_rs           = AW'($urandom_range(0, 3));
      id_rt           = AW'($urandom_range(0, 3));
      idex_mem_read   = $urandom_range(0, 1);
      idex_rt         = AW'($urandom_range(0, 3));
      ex_rs           = AW'($urandom_range(0, 3));
      ex_rt           = AW'($urandom_range(0, 3));
      exmem_reg_write = $urandom_range(0, 1);
      exmem_rd        = AW'($urandom_range(0, 3));
      memwb_reg_write = $urandom_range(0, 1);
      memwb_rd        = AW'($urandom_range(0, 3));
      cyc("R2", "R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule